// File: doc/BRIEF.md
# Serial Frame Parity and Acknowledge Sequencer

This block is the receive-side field sequencer of a unit on a multi-master serial bus. A bit decoder in front of it hands over one decoded bit at a time with a strobe, and raises a flag when a bit had a bad waveform. The sequencer splits the stream into fields in this order: master address, slave address, control, message length and then the data bytes. It checks the even parity bit that closes each field. At every acknowledge slot it decides whether to answer ACK or NAK.

A frame is opened by a one-cycle start strobe. The broadcast mode is latched on that same strobe. When the unit answers NAK, the frame ends with an abort pulse that carries a cause code, and the unit then waits for the next start strobe. Data bytes that are accepted come out one at a time. A frame that completes cleanly ends with a done pulse.

Top module: `frame_ack_seq`

## Requirements
- R1: Out of reset, ack_pend_o, abort_o, done_o and byte_valid_o are all 0.
- R2: Field widths are 12, 12, 4, 8 and 8 bits, sent MSB first. Each field is followed by one parity bit, and that bit is correct when it equals the XOR of the field bits. ack_pend_o goes to 1 in the cycle after the parity bit of the slave address, control, message length or a data field is consumed. It never goes to 1 after the master address field. It stays at 1 with a stable ack_bit_o until the next bit strobe consumes the slot bit.
- R3: ack_bit_o is 0 for ACK and 1 for NAK. A unicast frame with no error gets 0 at every slot.
- R4: If the master address parity or the slave address parity is wrong, the slave address slot is NAK and the abort cause is 1.
- R5: A timing error flagged since the previous slot makes that slot NAK with cause 2. This cause takes precedence over every other cause.
- R6: In a unicast frame, a slave address that differs from own_addr_i makes the slave address slot NAK with cause 3.
- R7: A parity error in the control field, the length field or a data field makes that field's slot NAK, with cause 4, 5 or 6 respectively.
- R8: In a broadcast frame ack_bit_o is 1 at every slot and an address mismatch is not an error. Parity and timing errors still abort the frame.
- R9: After a NAK slot bit is consumed, abort_o pulses for one cycle with cause_o. The unit then ignores bits until frame_start_i.
- R10: The number of data bytes received is the smaller of the length field and max_bytes_i. Each acknowledged byte appears on byte_o with a one-cycle byte_valid_o pulse after its slot. done_o pulses after the slot of the last byte, or after the length slot when no bytes are due.
- R11: frame_start_i restarts the field sequence from the master address in any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Frame start strobe |
| bcast_i | input | 1 | Broadcast mode, latched on frame start |
| own_addr_i | input | 12 | Address of this unit |
| max_bytes_i | input | 8 | Maximum number of data bytes per frame |
| bit_valid_i | input | 1 | Decoded bit strobe |
| bit_i | input | 1 | Decoded bit value |
| timing_err_i | input | 1 | Bit format error from the decoder |
| ack_pend_o | output | 1 | Acknowledge slot pending |
| ack_bit_o | output | 1 | Acknowledge value: 0 ACK, 1 NAK |
| abort_o | output | 1 | Abort pulse |
| cause_o | output | 3 | Abort cause code |
| done_o | output | 1 | Frame complete pulse |
| byte_valid_o | output | 1 | Data byte strobe |
| byte_o | output | 8 | Received data byte |

## Verification
A bit counter that slips shows within one field. It moves the acknowledge slot to the wrong place, so ack_pend_o rises one bit early or late and the next slot bit is read as field data. A parity or address decision stored in the wrong state shows in the first slot that follows, as a wrong ack_bit_o level. One slot bit later it shows again, as a missing abort pulse or one with the wrong cause_o. A byte limit that is off by one shows only at the end of the frame, as an extra or missing byte_valid_o pulse and a done_o pulse in the wrong place.

// File: rtl/frame_ack_pkg.sv
package frame_ack_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FIELD, ST_ACK} seq_st_e;
  typedef enum logic [2:0] {F_MADDR, F_SADDR, F_CTRL, F_LEN, F_DATA} fld_e;
  typedef enum logic [2:0] {
    C_NONE     = 3'd0,
    C_ADDR_PAR = 3'd1,
    C_TIMING   = 3'd2,
    C_NO_MATCH = 3'd3,
    C_CTRL_PAR = 3'd4,
    C_LEN_PAR  = 3'd5,
    C_DATA_PAR = 3'd6
  } cause_e;
endpackage

// File: rtl/field_shift.sv
module field_shift #(
  parameter int SH_W  = 12,
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             shift_i,
  input  logic             is_par_i,
  input  logic             bit_i,
  output logic [SH_W-1:0]  data_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             par_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      cnt_o  <= '0;
      par_o  <= 1'b0;
    end else if (clr_i) begin
      data_o <= '0;
      cnt_o  <= '0;
      par_o  <= 1'b0;
    end else if (shift_i) begin
      cnt_o <= cnt_o + 1'b1;
      par_o <= par_o ^ bit_i;
      if (!is_par_i) data_o <= {data_o[SH_W-2:0], bit_i};
    end
  end
endmodule

// File: rtl/ack_judge.sv
module ack_judge
  import frame_ack_pkg::*;
(
  input  fld_e   fld_i,
  input  logic   par_err_i,
  input  logic   ma_err_i,
  input  logic   tmo_i,
  input  logic   match_i,
  input  logic   bcast_i,
  output logic   nak_o,
  output cause_e cause_o
);
  always_comb begin
    cause_o = C_NONE;
    if (tmo_i) cause_o = C_TIMING;
    else begin
      unique case (fld_i)
        F_SADDR: begin
          if (ma_err_i || par_err_i)   cause_o = C_ADDR_PAR;
          else if (!bcast_i && !match_i) cause_o = C_NO_MATCH;
        end
        F_CTRL:  if (par_err_i) cause_o = C_CTRL_PAR;
        F_LEN:   if (par_err_i) cause_o = C_LEN_PAR;
        F_DATA:  if (par_err_i) cause_o = C_DATA_PAR;
        default: cause_o = C_NONE;
      endcase
    end
    nak_o = (cause_o != C_NONE);
  end
endmodule

// File: rtl/frame_ack_seq.sv
module frame_ack_seq
  import frame_ack_pkg::*;
#(
  parameter int MA_W = 12,
  parameter int SA_W = 12,
  parameter int CT_W = 4,
  parameter int LN_W = 8,
  parameter int DB_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            frame_start_i,
  input  logic            bcast_i,
  input  logic [SA_W-1:0] own_addr_i,
  input  logic [LN_W-1:0] max_bytes_i,
  input  logic            bit_valid_i,
  input  logic            bit_i,
  input  logic            timing_err_i,
  output logic            ack_pend_o,
  output logic            ack_bit_o,
  output logic            abort_o,
  output logic [2:0]      cause_o,
  output logic            done_o,
  output logic            byte_valid_o,
  output logic [DB_W-1:0] byte_o
);
  localparam int W01   = (MA_W > SA_W) ? MA_W : SA_W;
  localparam int W23   = (CT_W > LN_W) ? CT_W : LN_W;
  localparam int W03   = (W01 > W23) ? W01 : W23;
  localparam int SH_W  = (W03 > DB_W) ? W03 : DB_W;
  localparam int CNT_W = $clog2(SH_W + 1);

  function automatic logic [CNT_W-1:0] fld_width(fld_e f);
    case (f)
      F_MADDR: return CNT_W'(MA_W);
      F_SADDR: return CNT_W'(SA_W);
      F_CTRL:  return CNT_W'(CT_W);
      F_LEN:   return CNT_W'(LN_W);
      default: return CNT_W'(DB_W);
    endcase
  endfunction

  seq_st_e         st_q;
  fld_e            fld_q;
  logic            bcast_q, tmo_q, ma_err_q, nak_q;
  cause_e          cause_q;
  logic [LN_W-1:0] limit_q, bcnt_q;
  logic [DB_W-1:0] byte_q;

  logic [SH_W-1:0]  sh_data;
  logic [CNT_W-1:0] sh_cnt;
  logic             sh_par;
  logic             is_par, shift, clr, par_err, nak;
  cause_e           cause;
  logic [LN_W-1:0]  len_val;
  logic [LN_W:0]    bcnt_nx;

  assign is_par  = (sh_cnt == fld_width(fld_q));
  assign shift   = (st_q == ST_FIELD) && bit_valid_i && !frame_start_i;
  assign clr     = frame_start_i || (shift && is_par);
  assign par_err = sh_par ^ bit_i;
  assign len_val = sh_data[LN_W-1:0];
  assign bcnt_nx = {1'b0, bcnt_q} + 1'b1;

  field_shift #(.SH_W(SH_W), .CNT_W(CNT_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .shift_i (shift),
    .is_par_i(is_par),
    .bit_i   (bit_i),
    .data_o  (sh_data),
    .cnt_o   (sh_cnt),
    .par_o   (sh_par)
  );

  ack_judge u_judge (
    .fld_i    (fld_q),
    .par_err_i(par_err),
    .ma_err_i (ma_err_q),
    .tmo_i    (tmo_q || timing_err_i),
    .match_i  (sh_data[SA_W-1:0] == own_addr_i),
    .bcast_i  (bcast_q),
    .nak_o    (nak),
    .cause_o  (cause)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      fld_q        <= F_MADDR;
      bcast_q      <= 1'b0;
      tmo_q        <= 1'b0;
      ma_err_q     <= 1'b0;
      nak_q        <= 1'b0;
      cause_q      <= C_NONE;
      limit_q      <= '0;
      bcnt_q       <= '0;
      byte_q       <= '0;
      abort_o      <= 1'b0;
      cause_o      <= 3'd0;
      done_o       <= 1'b0;
      byte_valid_o <= 1'b0;
      byte_o       <= '0;
    end else begin
      abort_o      <= 1'b0;
      done_o       <= 1'b0;
      byte_valid_o <= 1'b0;
      if (frame_start_i) begin
        st_q     <= ST_FIELD;
        fld_q    <= F_MADDR;
        bcast_q  <= bcast_i;
        tmo_q    <= 1'b0;
        ma_err_q <= 1'b0;
        nak_q    <= 1'b0;
      end else begin
        if (st_q != ST_IDLE && timing_err_i) tmo_q <= 1'b1;
        if (shift && is_par) begin
          if (fld_q == F_MADDR) begin
            ma_err_q <= par_err;
            fld_q    <= F_SADDR;
          end else begin
            st_q    <= ST_ACK;
            nak_q   <= nak;
            cause_q <= cause;
            if (fld_q == F_LEN)
              limit_q <= (len_val < max_bytes_i) ? len_val : max_bytes_i;
            if (fld_q == F_DATA) byte_q <= sh_data[DB_W-1:0];
          end
        end else if (st_q == ST_ACK && bit_valid_i) begin
          tmo_q <= 1'b0;
          if (nak_q) begin
            abort_o <= 1'b1;
            cause_o <= cause_q;
            st_q    <= ST_IDLE;
          end else begin
            st_q <= ST_FIELD;
            unique case (fld_q)
              F_SADDR: fld_q <= F_CTRL;
              F_CTRL:  fld_q <= F_LEN;
              F_LEN: begin
                bcnt_q <= '0;
                fld_q  <= F_DATA;
                if (limit_q == '0) begin
                  done_o <= 1'b1;
                  st_q   <= ST_IDLE;
                end
              end
              default: begin
                byte_valid_o <= 1'b1;
                byte_o       <= byte_q;
                bcnt_q       <= bcnt_nx[LN_W-1:0];
                if (bcnt_nx == {1'b0, limit_q}) begin
                  done_o <= 1'b1;
                  st_q   <= ST_IDLE;
                end
              end
            endcase
          end
        end
      end
    end
  end

  assign ack_pend_o = (st_q == ST_ACK);
  assign ack_bit_o  = (st_q == ST_ACK) && (bcast_q || nak_q);
endmodule

// File: rtl/frame_ack_chk.sv
module frame_ack_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       frame_start_i,
  input logic       bit_valid_i,
  input logic       bcast_q,
  input logic       ack_pend_o,
  input logic       ack_bit_o,
  input logic       abort_o,
  input logic [2:0] cause_o,
  input logic       done_o,
  input logic       byte_valid_o
);
  // R2
  ack_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_pend_o && !bit_valid_i && !frame_start_i |=> ack_pend_o && $stable(ack_bit_o));
  // R8
  bcast_nak_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_pend_o && bcast_q |-> ack_bit_o);
  // R9
  abort_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $past(ack_pend_o) && $past(bit_valid_i) && $past(ack_bit_o) && cause_o != 3'd0);
  // R10
  done_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(ack_pend_o) && $past(bit_valid_i) && !abort_o);
  // R10
  byte_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> !abort_o && !ack_pend_o);
endmodule

bind frame_ack_seq frame_ack_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_start_i(frame_start_i),
  .bit_valid_i  (bit_valid_i),
  .bcast_q      (bcast_q),
  .ack_pend_o   (ack_pend_o),
  .ack_bit_o    (ack_bit_o),
  .abort_o      (abort_o),
  .cause_o      (cause_o),
  .done_o       (done_o),
  .byte_valid_o (byte_valid_o)
);

// File: tb/tb_frame_ack_seq.sv
module tb_frame_ack_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0, bcast = 1'b0, bit_valid = 1'b0, bit_v = 1'b0, terr = 1'b0;
  logic [11:0] own_addr = 12'hA5C;
  logic [7:0]  max_bytes = 8'd4;
  logic ack_pend, ack_bit, abort, done, byte_valid;
  logic [2:0] cause;
  logic [7:0] byte_v;

  int n_chk = 0, n_err = 0;
  int abort_cnt = 0, done_cnt = 0, nbytes = 0;
  logic [2:0] last_cause = 3'd0;
  logic [7:0] got [0:15];

  always #10 clk = ~clk;

  frame_ack_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(frame_start), .bcast_i(bcast),
    .own_addr_i(own_addr), .max_bytes_i(max_bytes), .bit_valid_i(bit_valid),
    .bit_i(bit_v), .timing_err_i(terr), .ack_pend_o(ack_pend), .ack_bit_o(ack_bit),
    .abort_o(abort), .cause_o(cause), .done_o(done), .byte_valid_o(byte_valid),
    .byte_o(byte_v)
  );

  always @(negedge clk) begin
    if (abort) begin abort_cnt++; last_cause = cause; end
    if (done) done_cnt++;
    if (byte_valid) begin
      if (nbytes < 16) got[nbytes] = byte_v;
      nbytes++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input logic te);
    @(negedge clk); bit_v = b; bit_valid = 1'b1; terr = te;
    @(negedge clk); bit_valid = 1'b0; terr = 1'b0;
  endtask

  task automatic send_field(input logic [11:0] val, input int w, input bit bad, input bit te);
    logic p;
    p = 1'b0;
    for (int i = w - 1; i >= 0; i--) begin
      send_bit(val[i], te && (i == w - 1));
      p ^= val[i];
    end
    send_bit(p ^ bad, 1'b0);
  endtask

  // returns 1 when the slot was NAK
  task automatic slot(input bit exp_bit, input string tag, output bit nak_seen);
    check(ack_pend === 1'b1, {tag, " R2 slot pending"}, ack_pend, 1);
    check(ack_bit === exp_bit, {tag, " R3 ack level"}, ack_bit, exp_bit);
    nak_seen = ack_bit;
    send_bit(1'b1, 1'b0);
  endtask

  task automatic start(input logic bc);
    @(negedge clk); frame_start = 1'b1; bcast = bc;
    @(negedge clk); frame_start = 1'b0;
    abort_cnt = 0; done_cnt = 0; nbytes = 0; last_cause = 3'd0;
  endtask

  // badf: 1 MA, 2 SA, 3 CTRL, 4 LEN, 5 first data byte
  task automatic frame(input logic bc, input logic [11:0] sa, input logic [7:0] len,
                       input logic [7:0] maxb, input int badf, input bit te,
                       input logic [2:0] exp_cause, input string tag);
    bit nk;
    int lim, exp_bytes;
    bit stop;
    max_bytes = maxb;
    lim = (len < maxb) ? len : maxb;
    stop = 0;
    start(bc);
    send_field(12'h5A3, 12, badf == 1, 1'b0);
    check(ack_pend === 1'b0, {tag, " R2 no slot after master address"}, ack_pend, 0);
    send_field(sa, 12, badf == 2, te);
    slot(bc || exp_cause inside {3'd1, 3'd2, 3'd3}, {tag, " sa"}, nk);
    if (nk && !bc) stop = 1;
    if (exp_cause inside {3'd1, 3'd2, 3'd3}) stop = 1;
    if (!stop) begin
      send_field(12'h009, 4, badf == 3, 1'b0);
      slot(bc || exp_cause == 3'd4, {tag, " ctrl"}, nk);
      if (exp_cause == 3'd4) stop = 1;
    end
    if (!stop) begin
      send_field({4'h0, len}, 8, badf == 4, 1'b0);
      slot(bc || exp_cause == 3'd5, {tag, " len"}, nk);
      if (exp_cause == 3'd5) stop = 1;
    end
    if (!stop) begin
      for (int i = 0; i < lim; i++) begin
        send_field({4'h0, 8'h30 + 8'(i)}, 8, badf == 5 && i == 0, 1'b0);
        slot(bc || (exp_cause == 3'd6 && i == 0), {tag, " data"}, nk);
        if (exp_cause == 3'd6) break;
      end
    end
    repeat (3) @(negedge clk);
    exp_bytes = (exp_cause == 3'd0) ? lim : 0;
    check(abort_cnt == (exp_cause != 0 ? 1 : 0), {tag, " R9 abort count"}, abort_cnt, exp_cause != 0);
    check(last_cause == exp_cause, {tag, " R9 cause"}, last_cause, exp_cause);
    check(done_cnt == (exp_cause == 0 ? 1 : 0), {tag, " R10 done count"}, done_cnt, exp_cause == 0);
    check(nbytes == exp_bytes, {tag, " R10 byte count"}, nbytes, exp_bytes);
    for (int i = 0; i < exp_bytes && i < 16; i++)
      check(got[i] == 8'h30 + 8'(i), {tag, " R10 byte value"}, got[i], 8'h30 + i);
  endtask

  task automatic t_reset();
    check(ack_pend === 1'b0 && abort === 1'b0 && done === 1'b0 && byte_valid === 1'b0,
          "R1 reset outputs", {ack_pend, abort, done, byte_valid}, 0);
  endtask

  task automatic t_ignore_after_abort();
    int a0;
    a0 = abort_cnt;
    for (int i = 0; i < 40; i++) send_bit(1'(i % 3 == 0), 1'b0);
    check(ack_pend === 1'b0, "R9 idle after abort, no slot", ack_pend, 0);
    check(abort_cnt == a0 && done_cnt == 0 && nbytes == 0, "R9 idle after abort, no pulses",
          abort_cnt + done_cnt + nbytes, a0);
  endtask

  task automatic t_restart();
    start(1'b0);
    for (int i = 0; i < 7; i++) send_bit(1'b1, 1'b0);
    // R11 restart mid-field then a clean frame
    frame(1'b0, 12'hA5C, 8'd1, 8'd4, 0, 1'b0, 3'd0, "R11 restart");
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    frame(1'b0, 12'hA5C, 8'd2, 8'd4, 0, 1'b0, 3'd0, "R3 good unicast");
    frame(1'b0, 12'hA5C, 8'd2, 8'd4, 1, 1'b0, 3'd1, "R4 master addr parity");
    t_ignore_after_abort();
    frame(1'b0, 12'hA5C, 8'd2, 8'd4, 2, 1'b0, 3'd1, "R4 slave addr parity");
    frame(1'b0, 12'hA5C, 8'd2, 8'd4, 2, 1'b1, 3'd2, "R5 timing over parity");
    frame(1'b0, 12'h123, 8'd2, 8'd4, 0, 1'b0, 3'd3, "R6 no match");
    frame(1'b0, 12'hA5C, 8'd2, 8'd4, 3, 1'b0, 3'd4, "R7 ctrl parity");
    frame(1'b0, 12'hA5C, 8'd2, 8'd4, 4, 1'b0, 3'd5, "R7 len parity");
    frame(1'b0, 12'hA5C, 8'd3, 8'd4, 5, 1'b0, 3'd6, "R7 data parity");
    frame(1'b0, 12'hA5C, 8'd5, 8'd2, 0, 1'b0, 3'd0, "R10 length over max");
    frame(1'b0, 12'hA5C, 8'd3, 8'd3, 0, 1'b0, 3'd0, "R10 length equals max");
    frame(1'b0, 12'hA5C, 8'd0, 8'd4, 0, 1'b0, 3'd0, "R10 zero length");
    frame(1'b1, 12'h321, 8'd2, 8'd4, 0, 1'b0, 3'd0, "R8 broadcast mismatch ok");
    frame(1'b1, 12'hA5C, 8'd2, 8'd4, 3, 1'b0, 3'd4, "R8 broadcast ctrl parity");
    t_restart();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule